// File: doc/BRIEF.md
# Data-Phase Timeout Counter

This block watches the data phase of a memory-card host controller. Software programs a 16-bit timeout value and a unit-select bit through a write port. When a data phase begins, the counter loads the value and counts down. Each unit is either one card-clock cycle or a kilocycle of 1024 card-clock cycles. Only cycles in which the card-clock enable is high are counted.

Every data-activity strobe (a block sent or received) reloads the counter and restarts the kilocycle prescaler. A stop strobe disarms the counter. If the count runs out, a sticky timeout flag is raised. This flag sits with the other data-path error bits, and software clears it by writing a one. A programmed value of zero disables the timeout.

The value and the unit bit are held in a shadow copy. A start strobe copies them into the working copy. Writes made while a phase is running therefore only apply from the next start.

Top module: `dto_timer`

## Requirements
- R1: After reset the timeout flag is low, the counter is idle and the shadow value is zero.
- R2: In cycle mode (unit bit 0) with value N > 0, the flag reads high right after the N-th rising edge that has card_ce high and follows the start edge. The start edge itself never counts.
- R3: In kilocycle mode (unit bit 1) with value N > 0, the flag rises after N*1024 counted card_ce edges following the start edge.
- R4: Edges with card_ce low change neither the count nor the prescaler.
- R5: A data_act strobe while armed reloads the count from the working value and clears the prescaler. Counting restarts on the edge after it.
- R6: A start with a programmed value of zero leaves the counter idle, and the flag never rises from that phase.
- R7: A data_stop strobe disarms the counter, and no timeout follows.
- R8: The flag stays high until flag_clr is asserted. If expiry and flag_clr occur on the same edge, the flag is set.
- R9: Configuration writes made while armed do not change the running phase. A start uses the shadow contents held before that edge.
- R10: After an expiry the counter is idle. Clearing the flag does not bring it back until the next start.
- R11: A start while armed reloads the counter and restarts the full interval. On the same edge, start takes priority over data_stop and data_act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the shadow timeout configuration |
| cfg_limit | input | 16 | Timeout value to write (0 = no timeout) |
| cfg_kilo | input | 1 | Unit select to write: 0 single cycles, 1 kilocycles |
| flag_clr | input | 1 | Write-one-to-clear for the timeout flag |
| card_ce | input | 1 | Card-clock enable, one pulse per card clock |
| data_start | input | 1 | Data phase begins: load and arm |
| data_act | input | 1 | Data activity seen: reload while armed |
| data_stop | input | 1 | Data phase ends: disarm |
| tmo_flag | output | 1 | Sticky data-timeout status |

## Verification
The assertions check the invariants on every cycle:
- a frozen count and prescaler while card_ce is low;
- a non-zero count whenever the counter is armed;
- an idle counter after a zero-value start or a stop;
- the prescaler wrapping when a kilocycle tick occurs;
- a flag that only rises from an expiry and stays high until cleared.

The exact expiry edge can only be shown by the bench scenarios. These cover single-cycle and kilocycle units, gapped enables, mid-phase reloads, a restart while armed, and configuration writes during a running phase. A behavioural model compares against the design on every clock.

// File: rtl/dto_pkg.sv
package dto_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ARMED = 1'b1
  } dto_phase_e;

  typedef struct packed {
    logic arm;     // start of data phase: load from shadow and arm
    logic halt;    // end of data phase: disarm
    logic reload;  // any reload of count and prescaler (start or activity)
  } dto_cmd_t;

endpackage

// File: rtl/dto_cfg_regs.sv
module dto_cfg_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_limit,
  input  logic             wr_kilo,
  input  logic             capture,
  output logic [CNT_W-1:0] shd_limit,
  output logic [CNT_W-1:0] act_limit,
  output logic             act_kilo
);

  logic [CNT_W-1:0] shd_lim_q, shd_lim_d;
  logic             shd_kilo_q, shd_kilo_d;
  logic [CNT_W-1:0] act_lim_q, act_lim_d;
  logic             act_kilo_q, act_kilo_d;

  always_comb begin
    shd_lim_d  = shd_lim_q;
    shd_kilo_d = shd_kilo_q;
    act_lim_d  = act_lim_q;
    act_kilo_d = act_kilo_q;
    if (wr) begin
      shd_lim_d  = wr_limit;
      shd_kilo_d = wr_kilo;
    end
    if (capture) begin
      act_lim_d  = shd_lim_q;
      act_kilo_d = shd_kilo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_lim_q  <= '0;
      shd_kilo_q <= 1'b0;
      act_lim_q  <= '0;
      act_kilo_q <= 1'b0;
    end else begin
      shd_lim_q  <= shd_lim_d;
      shd_kilo_q <= shd_kilo_d;
      act_lim_q  <= act_lim_d;
      act_kilo_q <= act_kilo_d;
    end
  end

  assign shd_limit = shd_lim_q;
  assign act_limit = act_lim_q;
  assign act_kilo  = act_kilo_q;

  AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(act_lim_q) && $stable(act_kilo_q)); // R9

endmodule

// File: rtl/dto_prescaler.sv
module dto_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic clr,
  input  logic kilo,
  output logic tick
);

  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_wrap;

  always_comb begin
    at_wrap = (pre_q == PRE_LAST);
    pre_d   = pre_q;
    if (clr)
      pre_d = '0;
    else if (ce)
      pre_d = pre_q + 1'b1;
    tick = ce & ~clr & (~kilo | at_wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce && !clr |=> $stable(pre_q)); // R4
  AST_KTICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    kilo && tick |=> pre_q == '0); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre_q == '0); // R5

endmodule

// File: rtl/dto_countdown.sv
module dto_countdown
  import dto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dto_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             armed,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  dto_phase_e       ph_q, ph_d;

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    expire = 1'b0;
    if (cmd.arm) begin
      cnt_d = load_val;
      ph_d  = (load_val != '0) ? PH_ARMED : PH_IDLE;
    end else if (cmd.halt) begin
      ph_d = PH_IDLE;
    end else if (cmd.reload && ph_q == PH_ARMED) begin
      cnt_d = load_val;
    end else if (ph_q == PH_ARMED && tick) begin
      if (cnt_q == CNT_ONE) begin
        expire = 1'b1;
        ph_d   = PH_IDLE;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_IDLE;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign armed = (ph_q == PH_ARMED);

  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.arm && load_val == '0 |=> !armed); // R6
  AST_HALT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.halt && !cmd.arm |=> !armed); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cmd.arm && !cmd.halt && !cmd.reload |=> $stable(cnt_q)); // R4
  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cnt_q != '0); // R2
  AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed); // R10

endmodule

// File: rtl/dto_sticky_flag.sv
module dto_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R8

endmodule

// File: rtl/dto_timer.sv
module dto_timer
  import dto_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             cfg_kilo,
  input  logic             flag_clr,
  input  logic             card_ce,
  input  logic             data_start,
  input  logic             data_act,
  input  logic             data_stop,
  output logic             tmo_flag
);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_i_n;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q[gi] <= 1'b0;
        else        rs_q[gi] <= (gi == 0) ? 1'b1 : rs_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate
  assign rst_i_n = rs_q[SYNC_STAGES-1];

  logic [CNT_W-1:0] shd_limit, act_limit, load_val;
  logic             act_kilo, armed, expire, tick;
  dto_cmd_t         cmd;

  always_comb begin
    cmd.arm    = data_start;
    cmd.halt   = data_stop & ~data_start;
    cmd.reload = data_start | (data_act & ~data_stop & armed);
    load_val   = data_start ? shd_limit : act_limit;
  end

  dto_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr        (cfg_wr),
    .wr_limit  (cfg_limit),
    .wr_kilo   (cfg_kilo),
    .capture   (cmd.arm),
    .shd_limit (shd_limit),
    .act_limit (act_limit),
    .act_kilo  (act_kilo)
  );

  dto_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_i_n),
    .ce    (card_ce),
    .clr   (cmd.reload),
    .kilo  (act_kilo),
    .tick  (tick)
  );

  dto_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cmd      (cmd),
    .load_val (load_val),
    .tick     (tick),
    .armed    (armed),
    .expire   (expire)
  );

  dto_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set   (expire),
    .clr   (flag_clr),
    .flag  (tmo_flag)
  );

  AST_RISE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tmo_flag ##1 tmo_flag |-> $past(expire)); // R2
  AST_START_BEATS_STOP: assert property (@(posedge clk) disable iff (!rst_i_n)
    data_start && data_stop && shd_limit != '0 |=> armed); // R11

endmodule

// File: tb/sim_dto_timer.sv
module sim_dto_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_limit = '0;
  logic        cfg_kilo = 1'b0;
  logic        flag_clr = 1'b0;
  logic        card_ce;
  logic        data_start = 1'b0;
  logic        data_act = 1'b0;
  logic        data_stop = 1'b0;
  logic        tmo_flag;

  always #10 clk = ~clk; // 50 MHz

  dto_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_limit(cfg_limit),
    .cfg_kilo(cfg_kilo), .flag_clr(flag_clr), .card_ce(card_ce),
    .data_start(data_start), .data_act(data_act), .data_stop(data_stop),
    .tmo_flag(tmo_flag)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    ce_mode = 1;   // 0 off, 1 always, 2 every other cycle
  string cur_req = "R1";
  bit    done = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (ce_mode)
      0: card_ce <= 1'b0;
      2: card_ce <= cyc[0];
      default: card_ce <= 1'b1;
    endcase
  end

  // behavioural reference
  int m_rem, m_pre, m_shd_lim, m_act_lim;
  bit m_armed, m_flag, m_shd_kilo, m_act_kilo;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_pre = 0; m_shd_lim = 0; m_act_lim = 0;
      m_armed = 0; m_flag = 0; m_shd_kilo = 0; m_act_kilo = 0;
    end else begin
      bit tk, fire, reloaded;
      tk = card_ce && (!m_act_kilo || m_pre == 1023);
      fire = 0;
      reloaded = 0;
      if (data_start) begin
        m_rem = m_shd_lim; m_armed = (m_shd_lim != 0);
        m_act_lim = m_shd_lim; m_act_kilo = m_shd_kilo; reloaded = 1;
      end else if (data_stop) begin
        m_armed = 0;
      end else if (data_act && m_armed) begin
        m_rem = m_act_lim; reloaded = 1;
      end else if (m_armed && tk) begin
        if (m_rem == 1) begin fire = 1; m_armed = 0; m_rem = 0; end
        else m_rem = m_rem - 1;
      end
      if (reloaded) m_pre = 0;
      else if (card_ce) m_pre = (m_pre + 1) % 1024;
      if (fire) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (cfg_wr) begin m_shd_lim = cfg_limit; m_shd_kilo = cfg_kilo; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (tmo_flag !== m_flag) begin
        n_bad++;
        $display("FAIL %s: cycle %0d tmo_flag actual %b expected %b", cur_req, cyc, tmo_flag, m_flag);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit exp, input string req);
    n_vec++;
    if (tmo_flag !== exp) begin
      n_bad++;
      $display("FAIL %s: tmo_flag actual %b expected %b", req, tmo_flag, exp);
    end
  endtask

  task automatic write_cfg(input int lim, input bit kilo);
    cfg_wr = 1; cfg_limit = lim[15:0]; cfg_kilo = kilo;
    step(1);
    cfg_wr = 0;
  endtask

  task automatic pulse_start();
    data_start = 1; step(1); data_start = 0;
  endtask
  task automatic pulse_act();
    data_act = 1; step(1); data_act = 0;
  endtask
  task automatic pulse_stop();
    data_stop = 1; step(1); data_stop = 0;
  endtask
  task automatic pulse_clr();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: cycle %0d actual hung expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1;
    step(4);
    cur_req = "R1"; check(0, "R1");

    // R2 single-cycle expiry at the exact edge
    cur_req = "R2";
    write_cfg(5, 0);
    pulse_start();
    step(4); check(0, "R2");
    step(1); check(1, "R2");
    // R8 sticky until cleared
    cur_req = "R8";
    step(3); check(1, "R8");
    pulse_clr(); check(0, "R8");
    // R10 no re-fire after expiry
    cur_req = "R10";
    step(20); check(0, "R10");

    // R4 gapped enable
    cur_req = "R4";
    ce_mode = 2;
    write_cfg(6, 0);
    pulse_start();
    step(7); check(0, "R4");
    step(10); check(1, "R4");
    ce_mode = 0;
    pulse_clr();
    step(5);
    ce_mode = 1;
    step(2);

    // R3 kilocycle unit
    cur_req = "R3";
    write_cfg(2, 1);
    pulse_start();
    step(2047); check(0, "R3");
    step(1); check(1, "R3");
    pulse_clr();

    // R5 activity reload, cycle mode
    cur_req = "R5";
    write_cfg(10, 0);
    pulse_start();
    step(8);
    pulse_act();
    step(8); check(0, "R5");
    step(2); check(1, "R5");
    pulse_clr();
    // R5 activity clears the prescaler
    write_cfg(1, 1);
    pulse_start();
    step(1000);
    pulse_act();
    step(1023); check(0, "R5");
    step(1); check(1, "R5");
    pulse_clr();

    // R6 zero disables
    cur_req = "R6";
    write_cfg(0, 0);
    pulse_start();
    step(1500);
    pulse_act();
    step(1500); check(0, "R6");

    // R7 stop disarms
    cur_req = "R7";
    write_cfg(4, 0);
    pulse_start();
    step(2);
    pulse_stop();
    step(10); check(0, "R7");

    // R9 writes during a running phase
    cur_req = "R9";
    write_cfg(3, 0);
    pulse_start();
    write_cfg(100, 1);
    step(2); check(1, "R9");
    pulse_clr();
    pulse_start();
    step(3); check(0, "R9");
    pulse_stop();

    // R11 restart while armed
    cur_req = "R11";
    write_cfg(5, 0);
    pulse_start();
    step(3);
    pulse_start();
    step(4); check(0, "R11");
    step(1); check(1, "R11");
    pulse_clr();
    // R11 start beats stop on the same edge
    data_start = 1; data_stop = 1; step(1); data_start = 0; data_stop = 0;
    step(4); check(0, "R11");
    step(1); check(1, "R11");
    pulse_clr();

    // R8 expiry and clear on the same edge: set wins
    cur_req = "R8";
    write_cfg(2, 0);
    pulse_start();
    step(1);
    flag_clr = 1; step(1); flag_clr = 0;
    check(1, "R8");
    pulse_clr(); check(0, "R8");

    step(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule